// File: doc/BRIEF.md
# Linear Generator Jump-Ahead Accumulator

This block moves a word-oriented linear-recurrence random generator forward by a very large distance without stepping it that many times. An external source supplies the jump polynomial as a stream of coefficient bits. The unit walks the generator through successive full-state steps. Whenever the coefficient for the current power is one, it pulls the generator's whole state over a 32-bit word link and folds it into an accumulator memory with XOR. The result is the polynomial applied to the starting state.

When every term has been handled, the unit writes the accumulated state back through the same link, so it becomes the generator's new state. While a job runs, the unit holds the generator paused, so that the generator moves only on the step commands the unit issues. Coefficients are buffered first. A parameter picks whether the stream delivers the constant term first or the highest power first.

Top module: `jump_accum`

## Requirements
- R1: After reset, `busy`, `done`, `coef_ready`, `gen_cmd_valid`, `gen_rd_ready` and `gen_wr_valid` are all low.
- R2: A `start` pulse while idle makes `busy` high and `done` low on the next cycle. A `start` while busy is ignored, and the running job completes with an unchanged result.
- R3: `coef_ready` is high only during the loading phase of a job. The beat with `coef_last` high ends loading, and `coef_ready` is low from the next cycle.
- R4: With `HIGH_FIRST`=0, the first coefficient beat is the constant term (power 0). With `HIGH_FIRST`=1, the first beat is the highest power (beat count minus one) and the last beat is power 0.
- R5: For each coefficient equal to one, the unit issues exactly one read command (`gen_cmd_op`=1) and absorbs exactly `N_WORDS` words, XORing each into the accumulator word of the same index. A zero coefficient causes no read.
- R6: Between two consecutive powers, the unit issues exactly one step command (`gen_cmd_op`=0), advancing the generator by one full state. No step follows the highest power, so a job with T coefficients issues T-1 steps.
- R7: The accumulator is cleared at the start of every job, so no value from an earlier job reaches a later result.
- R8: Write-back is one write command (`gen_cmd_op`=2) followed by `N_WORDS` words in index order 0 to `N_WORDS`-1. The words equal the XOR of the selected intermediate states. Reading and writing never overlap.
- R9: `done` rises only in the cycle after the last write-back word is accepted, and stays high until the next accepted `start`. `gen_hold` is high exactly while `busy` is high.
- R10: `gen_cmd_valid`/`gen_cmd_op` and `gen_wr_valid`/`gen_wr_data` stay stable while the generator withholds its ready signal. Gaps in `gen_rd_valid` only stall the accumulation.
- R11: A polynomial whose coefficients are all zero writes back an all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a jump when idle |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished; held until next start |
| coef_valid | input | 1 | Coefficient beat valid |
| coef_bit | input | 1 | Coefficient value |
| coef_last | input | 1 | Final coefficient beat |
| coef_ready | output | 1 | Unit accepts coefficient beats |
| gen_hold | output | 1 | Pause request to the generator |
| gen_cmd_valid | output | 1 | Command to generator valid |
| gen_cmd_op | output | 2 | 0 step, 1 read state, 2 write state |
| gen_cmd_ready | input | 1 | Generator accepts a command |
| gen_rd_valid | input | 1 | State word from generator valid |
| gen_rd_data | input | W | State word from generator |
| gen_rd_ready | output | 1 | Unit absorbs state words |
| gen_wr_valid | output | 1 | Write-back word valid |
| gen_wr_data | output | W | Write-back word |
| gen_wr_ready | input | 1 | Generator accepts write-back word |

## Verification
The bench drives sparse, dense, single-term and all-zero polynomials. It compares the written-back state with a sum of stepped states computed separately. A unit that skips clearing the accumulator would leak an earlier job's state into the all-zero case. A unit that steps once too often, or once after the last power, would shift every term by a whole state and fail the step count. A second instance, configured for highest power first, takes a non-palindromic polynomial, so reversing the term order wrongly changes the result. The link-side model alternates valid and ready gaps, which exposes any pairing of an accumulator word with the wrong index. A `start` pulse injected mid-job would corrupt the result if it were honoured.

// File: rtl/jmp_pkg.sv
package jmp_pkg;

  // Command codes understood by the generator-side endpoint
  typedef enum logic [1:0] {
    OP_STEP  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } gen_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LOAD,
    S_CLEAR,
    S_PICK,
    S_DECIDE,
    S_RD_CMD,
    S_RD_STRM,
    S_STEP_CMD,
    S_WB_CMD,
    S_WB_STRM
  } jmp_state_e;

endpackage

// File: rtl/jmp_coef_buf.sv
// Packs incoming coefficient bits into words and replays them by power.
module jmp_coef_buf #(
  parameter int MAX_TERMS  = 19968,
  parameter int BUF_W      = 32,
  parameter bit HIGH_FIRST = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 clr,
  input  logic                                 wr_en,
  input  logic                                 wr_bit,
  input  logic                                 wr_last,
  output logic [$clog2(MAX_TERMS+1)-1:0]       count,
  input  logic [$clog2(MAX_TERMS+1)-1:0]       rd_term,
  output logic                                 rd_bit
);
  localparam int TERM_W = $clog2(MAX_TERMS + 1);
  localparam int BW     = $clog2(BUF_W);
  localparam int DEPTH  = (MAX_TERMS + BUF_W - 1) / BUF_W;
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BUF_W-1:0]  mem [DEPTH];
  logic [BUF_W-1:0]  pack, pack_nxt, rd_word;
  logic [BW-1:0]     pos, sel;
  logic [TERM_W-1:0] phys;
  logic              wr_ok, flush;

  assign wr_ok = wr_en && (count < TERM_W'(MAX_TERMS));
  assign pos   = count[BW-1:0];
  assign flush = wr_ok && ((pos == BW'(BUF_W - 1)) || wr_last);

  always_comb begin
    pack_nxt      = pack;
    pack_nxt[pos] = wr_bit;
  end

  // Stream order decides which stored bit belongs to a given power
  generate
    if (HIGH_FIRST) begin : g_rev
      assign phys = count - rd_term - TERM_W'(1);
    end else begin : g_fwd
      assign phys = rd_term;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
      pack  <= '0;
    end else if (wr_ok) begin
      count <= count + TERM_W'(1);
      pack  <= flush ? '0 : pack_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (flush) mem[AW'(count >> BW)] <= pack_nxt;
    rd_word <= mem[AW'(phys >> BW)];
    sel     <= phys[BW-1:0];
  end

  assign rd_bit = rd_word[sel];

endmodule

// File: rtl/jmp_acc_ram.sv
// Simple dual-port accumulator store, registered read.
module jmp_acc_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 624
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/jump_accum.sv
module jump_accum
  import jmp_pkg::*;
#(
  parameter int W          = 32,
  parameter int N_WORDS    = 624,
  parameter int MAX_TERMS  = 19968,
  parameter bit HIGH_FIRST = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic         busy,
  output logic         done,
  input  logic         coef_valid,
  input  logic         coef_bit,
  input  logic         coef_last,
  output logic         coef_ready,
  output logic         gen_hold,
  output logic         gen_cmd_valid,
  output logic [1:0]   gen_cmd_op,
  input  logic         gen_cmd_ready,
  input  logic         gen_rd_valid,
  input  logic [W-1:0] gen_rd_data,
  output logic         gen_rd_ready,
  output logic         gen_wr_valid,
  output logic [W-1:0] gen_wr_data,
  input  logic         gen_wr_ready
);
  localparam int IDX_W  = $clog2(N_WORDS);
  localparam int TERM_W = $clog2(MAX_TERMS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_WORDS - 1);

  jmp_state_e        state;
  logic [IDX_W-1:0]  widx, addr_next;
  logic [TERM_W-1:0] term, count;
  logic [W-1:0]      acc_q, acc_wd;
  logic              acc_we, adv, idx_last, term_last;
  logic              rd_fire, wr_fire, cbit, done_q;

  // ---------------- coefficient buffer ----------------
  jmp_coef_buf #(
    .MAX_TERMS (MAX_TERMS),
    .BUF_W     (32),
    .HIGH_FIRST(HIGH_FIRST)
  ) u_coef (
    .clk    (clk),
    .rst    (rst),
    .clr    (state == S_IDLE && start),
    .wr_en  (state == S_LOAD && coef_valid),
    .wr_bit (coef_bit),
    .wr_last(coef_last),
    .count  (count),
    .rd_term(term),
    .rd_bit (cbit)
  );

  // ---------------- accumulator store ----------------
  jmp_acc_ram #(
    .W    (W),
    .DEPTH(N_WORDS)
  ) u_acc (
    .clk  (clk),
    .we   (acc_we),
    .waddr(widx),
    .wdata(acc_wd),
    .raddr(addr_next),
    .rdata(acc_q)
  );

  assign rd_fire   = (state == S_RD_STRM) && gen_rd_valid;
  assign wr_fire   = (state == S_WB_STRM) && gen_wr_ready;
  assign idx_last  = (widx == IDX_LAST);
  assign term_last = (term == count - TERM_W'(1));

  // The store always reads the word the next accepted beat will touch,
  // so its registered output lines up with the current index.
  always_comb begin
    adv       = (state == S_CLEAR) || rd_fire || wr_fire;
    addr_next = widx;
    if (adv) addr_next = idx_last ? '0 : widx + IDX_W'(1);
    acc_we    = (state == S_CLEAR) || rd_fire;
    acc_wd    = (state == S_CLEAR) ? '0 : (acc_q ^ gen_rd_data);
  end

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      widx   <= '0;
      term   <= '0;
      done_q <= 1'b0;
    end else begin
      widx <= addr_next;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state  <= S_LOAD;
            done_q <= 1'b0;
            term   <= '0;
          end
        end
        S_LOAD:   if (coef_valid && coef_last) state <= S_CLEAR;
        S_CLEAR:  if (idx_last) state <= S_PICK;
        S_PICK:   state <= S_DECIDE;
        S_DECIDE: begin
          if (cbit)           state <= S_RD_CMD;
          else if (term_last) state <= S_WB_CMD;
          else                state <= S_STEP_CMD;
        end
        S_RD_CMD: if (gen_cmd_ready) state <= S_RD_STRM;
        S_RD_STRM: begin
          if (rd_fire && idx_last) state <= term_last ? S_WB_CMD : S_STEP_CMD;
        end
        S_STEP_CMD: begin
          if (gen_cmd_ready) begin
            term  <= term + TERM_W'(1);
            state <= S_PICK;
          end
        end
        S_WB_CMD: if (gen_cmd_ready) state <= S_WB_STRM;
        S_WB_STRM: begin
          if (wr_fire && idx_last) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    busy          = (state != S_IDLE);
    gen_hold      = busy;
    done          = done_q;
    coef_ready    = (state == S_LOAD);
    gen_rd_ready  = (state == S_RD_STRM);
    gen_wr_valid  = (state == S_WB_STRM);
    gen_wr_data   = acc_q;
    gen_cmd_valid = (state == S_RD_CMD) || (state == S_STEP_CMD) || (state == S_WB_CMD);
    gen_cmd_op    = (state == S_RD_CMD)   ? OP_READ :
                    (state == S_STEP_CMD) ? OP_STEP : OP_WRITE;
  end

endmodule

// File: rtl/jmp_accum_chk.sv
module jmp_accum_chk #(
  parameter int W       = 32,
  parameter int N_WORDS = 624
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         coef_ready,
  input logic         gen_cmd_valid,
  input logic [1:0]   gen_cmd_op,
  input logic         gen_cmd_ready,
  input logic         gen_rd_ready,
  input logic         gen_wr_valid,
  input logic [W-1:0] gen_wr_data,
  input logic         gen_wr_ready
);
  logic [31:0] wb_cnt;

  always_ff @(posedge clk) begin
    if (rst) wb_cnt <= '0;
    else if (start && !busy) wb_cnt <= '0;
    else if (gen_wr_valid && gen_wr_ready) wb_cnt <= wb_cnt + 32'd1;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && !done);

  p_coef_ready_r3: assert property (@(posedge clk) disable iff (rst)
    coef_ready |-> busy);

  p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(gen_rd_ready && gen_wr_valid));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);

  p_done_count_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> wb_cnt == 32'(N_WORDS));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_cmd_stable_r10: assert property (@(posedge clk) disable iff (rst)
    gen_cmd_valid && !gen_cmd_ready |=> gen_cmd_valid && $stable(gen_cmd_op));

  p_wr_stable_r10: assert property (@(posedge clk) disable iff (rst)
    gen_wr_valid && !gen_wr_ready |=> gen_wr_valid && $stable(gen_wr_data));

endmodule

bind jump_accum jmp_accum_chk #(.W(W), .N_WORDS(N_WORDS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .coef_ready   (coef_ready),
  .gen_cmd_valid(gen_cmd_valid),
  .gen_cmd_op   (gen_cmd_op),
  .gen_cmd_ready(gen_cmd_ready),
  .gen_rd_ready (gen_rd_ready),
  .gen_wr_valid (gen_wr_valid),
  .gen_wr_data  (gen_wr_data),
  .gen_wr_ready (gen_wr_ready)
);

// File: tb/tb_jump_accum.sv
// Generator-side endpoint model: executes step/read/write commands.
module tb_gen_model #(
  parameter int N = 624,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         cmd_valid,
  input  logic [1:0]   cmd_op,
  output logic         cmd_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_ready,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         gaps
);
  logic [W-1:0] st [N];
  int mode, idx, wait_c;
  int n_step, n_rdcmd, n_rdword, n_wrword;
  logic tog;

  assign cmd_ready = (mode == 0);
  assign rd_valid  = (mode == 1) && (!gaps || tog);
  assign rd_data   = st[idx];
  assign wr_ready  = (mode == 2) && (!gaps || !tog);

  always @(posedge clk) begin
    tog <= ~tog;
    if (rst) begin
      mode <= 0; idx <= 0; wait_c <= 0; tog <= 1'b0;
      n_step <= 0; n_rdcmd <= 0; n_rdword <= 0; n_wrword <= 0;
      for (int i = 0; i < N; i++) st[i] <= W'(32'h1234_5679 * (i + 1)) ^ W'(i << 7);
    end else begin
      case (mode)
        0: if (cmd_valid) begin
          if (cmd_op == 2'd0) begin
            for (int i = 0; i < N; i++)
              st[i] <= st[(i + 1) % N] ^ (st[i] >> 1) ^ (st[i][0] ? 32'h9908_B0DF : 32'h0);
            n_step <= n_step + 1; mode <= 3; wait_c <= 3;
          end else if (cmd_op == 2'd1) begin
            mode <= 1; idx <= 0; n_rdcmd <= n_rdcmd + 1;
          end else if (cmd_op == 2'd2) begin
            mode <= 2; idx <= 0;
          end
        end
        1: if (rd_valid && rd_ready) begin
          n_rdword <= n_rdword + 1;
          if (idx == N - 1) begin idx <= 0; mode <= 0; end
          else idx <= idx + 1;
        end
        2: if (wr_valid && wr_ready) begin
          st[idx] <= wr_data;
          n_wrword <= n_wrword + 1;
          if (idx == N - 1) begin idx <= 0; mode <= 0; end
          else idx <= idx + 1;
        end
        default: begin
          wait_c <= wait_c - 1;
          if (wait_c == 1) mode <= 0;
        end
      endcase
    end
  end
endmodule

module tb_jump_accum;
  localparam int N = 624;
  localparam int W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst;

  logic start_s[2], coef_valid_s[2], coef_bit_s[2], coef_last_s[2], gaps_s[2];
  logic busy_s[2], done_s[2], coef_ready_s[2], hold_s[2];
  logic cmd_valid_s[2], cmd_ready_s[2], rd_valid_s[2], rd_ready_s[2];
  logic wr_valid_s[2], wr_ready_s[2];
  logic [1:0]   cmd_op_s[2];
  logic [W-1:0] rd_data_s[2], wr_data_s[2];

  jump_accum #(.W(W), .N_WORDS(N), .HIGH_FIRST(1'b0)) dut (
    .clk(clk), .rst(rst), .start(start_s[0]), .busy(busy_s[0]), .done(done_s[0]),
    .coef_valid(coef_valid_s[0]), .coef_bit(coef_bit_s[0]), .coef_last(coef_last_s[0]),
    .coef_ready(coef_ready_s[0]), .gen_hold(hold_s[0]),
    .gen_cmd_valid(cmd_valid_s[0]), .gen_cmd_op(cmd_op_s[0]), .gen_cmd_ready(cmd_ready_s[0]),
    .gen_rd_valid(rd_valid_s[0]), .gen_rd_data(rd_data_s[0]), .gen_rd_ready(rd_ready_s[0]),
    .gen_wr_valid(wr_valid_s[0]), .gen_wr_data(wr_data_s[0]), .gen_wr_ready(wr_ready_s[0]));

  jump_accum #(.W(W), .N_WORDS(N), .HIGH_FIRST(1'b1)) dut_hi (
    .clk(clk), .rst(rst), .start(start_s[1]), .busy(busy_s[1]), .done(done_s[1]),
    .coef_valid(coef_valid_s[1]), .coef_bit(coef_bit_s[1]), .coef_last(coef_last_s[1]),
    .coef_ready(coef_ready_s[1]), .gen_hold(hold_s[1]),
    .gen_cmd_valid(cmd_valid_s[1]), .gen_cmd_op(cmd_op_s[1]), .gen_cmd_ready(cmd_ready_s[1]),
    .gen_rd_valid(rd_valid_s[1]), .gen_rd_data(rd_data_s[1]), .gen_rd_ready(rd_ready_s[1]),
    .gen_wr_valid(wr_valid_s[1]), .gen_wr_data(wr_data_s[1]), .gen_wr_ready(wr_ready_s[1]));

  tb_gen_model #(.N(N), .W(W)) gm0 (
    .clk(clk), .rst(rst), .hold(hold_s[0]), .cmd_valid(cmd_valid_s[0]), .cmd_op(cmd_op_s[0]),
    .cmd_ready(cmd_ready_s[0]), .rd_valid(rd_valid_s[0]), .rd_data(rd_data_s[0]),
    .rd_ready(rd_ready_s[0]), .wr_valid(wr_valid_s[0]), .wr_data(wr_data_s[0]),
    .wr_ready(wr_ready_s[0]), .gaps(gaps_s[0]));

  tb_gen_model #(.N(N), .W(W)) gm1 (
    .clk(clk), .rst(rst), .hold(hold_s[1]), .cmd_valid(cmd_valid_s[1]), .cmd_op(cmd_op_s[1]),
    .cmd_ready(cmd_ready_s[1]), .rd_valid(rd_valid_s[1]), .rd_data(rd_data_s[1]),
    .rd_ready(rd_ready_s[1]), .wr_valid(wr_valid_s[1]), .wr_data(wr_data_s[1]),
    .wr_ready(wr_ready_s[1]), .gaps(gaps_s[1]));

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] cur [N];
  logic [W-1:0] nxt [N];
  logic [W-1:0] expv [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_word(input int k, input int i);
    return (k == 0) ? gm0.st[i] : gm1.st[i];
  endfunction

  function automatic int model_cnt(input int k, input int sel);
    if (k == 0) return (sel == 0) ? gm0.n_step : (sel == 1) ? gm0.n_rdcmd :
                       (sel == 2) ? gm0.n_rdword : gm0.n_wrword;
    return (sel == 0) ? gm1.n_step : (sel == 1) ? gm1.n_rdcmd :
           (sel == 2) ? gm1.n_rdword : gm1.n_wrword;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    for (int k = 0; k < 2; k++) begin
      start_s[k] = 0; coef_valid_s[k] = 0; coef_bit_s[k] = 0;
      coef_last_s[k] = 0; gaps_s[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      // R1: quiet outputs after reset
      chk(!busy_s[k] && !done_s[k], "R1", "busy/done after reset",
          {busy_s[k], done_s[k]}, 0);
      chk(!coef_ready_s[k] && !cmd_valid_s[k] && !rd_ready_s[k] && !wr_valid_s[k],
          "R1", "handshakes after reset",
          {coef_ready_s[k], cmd_valid_s[k], rd_ready_s[k], wr_valid_s[k]}, 0);
    end
  endtask

  // One jump: poly bit d is the coefficient of power d.
  task automatic run_job(input int k, input int nt, input logic [31:0] poly,
                         input bit gaps, input bit poke, input string req);
    int s0, r0, rw0, w0, pc, mism;
    gaps_s[k] = gaps;
    for (int i = 0; i < N; i++) begin cur[i] = model_word(k, i); expv[i] = '0; end
    pc = 0;
    for (int d = 0; d < nt; d++) begin
      if (poly[d]) begin
        pc++;
        for (int i = 0; i < N; i++) expv[i] = expv[i] ^ cur[i];
      end
      if (d != nt - 1) begin
        for (int i = 0; i < N; i++)
          nxt[i] = cur[(i + 1) % N] ^ (cur[i] >> 1) ^ (cur[i][0] ? 32'h9908_B0DF : 32'h0);
        for (int i = 0; i < N; i++) cur[i] = nxt[i];
      end
    end
    s0 = model_cnt(k, 0); r0 = model_cnt(k, 1); rw0 = model_cnt(k, 2); w0 = model_cnt(k, 3);

    @(negedge clk); start_s[k] = 1'b1;
    @(negedge clk); start_s[k] = 1'b0;
    chk(busy_s[k] && !done_s[k], "R2", "busy after start", {busy_s[k], done_s[k]}, 2'b10);
    chk(hold_s[k] == 1'b1, "R9", "hold while busy", hold_s[k], 1);

    for (int b = 0; b < nt; b++) begin
      int d;
      d = (k == 0) ? b : nt - 1 - b;  // R4: stream order per instance
      coef_valid_s[k] = 1'b1;
      coef_bit_s[k]   = poly[d];
      coef_last_s[k]  = (b == nt - 1);
      while (!coef_ready_s[k]) @(negedge clk);
      @(negedge clk);
    end
    coef_valid_s[k] = 1'b0; coef_last_s[k] = 1'b0;
    chk(!coef_ready_s[k], "R3", "ready after last beat", coef_ready_s[k], 0);

    if (poke) begin
      repeat (40) @(negedge clk);
      start_s[k] = 1'b1;   // R2: must be ignored
      @(negedge clk);
      start_s[k] = 1'b0;
    end

    while (!done_s[k]) @(negedge clk);
    chk(!busy_s[k] && !hold_s[k], "R9", "idle with done", {busy_s[k], hold_s[k]}, 0);
    chk(model_cnt(k, 3) - w0 == N, "R9", "words written before done", model_cnt(k, 3) - w0, N);
    chk(model_cnt(k, 0) - s0 == nt - 1, "R6", "step commands", model_cnt(k, 0) - s0, nt - 1);
    chk(model_cnt(k, 1) - r0 == pc, "R5", "read commands", model_cnt(k, 1) - r0, pc);
    chk(model_cnt(k, 2) - rw0 == pc * N, "R5", "read words", model_cnt(k, 2) - rw0, pc * N);

    mism = 0;
    for (int i = 0; i < N; i++) if (model_word(k, i) !== expv[i]) mism++;
    chk(mism == 0, req, "written-back state mismatching words", mism, 0);
    chk(model_word(k, 0) === expv[0], "R8", "word 0 of new state", model_word(k, 0), expv[0]);

    repeat (3) @(negedge clk);
    chk(done_s[k] && !busy_s[k], "R9", "done held after finish", {done_s[k], busy_s[k]}, 2'b10);
    gaps_s[k] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog: actual unfinished expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    run_job(0, 8, 32'h0000_00B5, 1'b0, 1'b0, "R5");   // sparse mix
    run_job(0, 11, 32'h0000_04D3, 1'b1, 1'b1, "R10"); // link gaps, stray start (R2)
    run_job(0, 5, 32'h0, 1'b0, 1'b0, "R11");          // all zero; also R7 clearing
    run_job(0, 1, 32'h1, 1'b0, 1'b0, "R6");           // single term, no step
    run_job(1, 7, 32'h0000_004B, 1'b0, 1'b0, "R4");   // highest power first
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule